// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block is a purely combinational N-bit binary adder with a carry input and a carry output. The default width is 16 bits and it builds unchanged at 32. The operand width is cut into groups that get wider from the least significant end upward. The bottom group is a plain adder driven straight from the carry input. Every group above it forms its partial sum once, with a carry-in of zero. The result for a carry-in of one comes from a cheap increment of that first result, not from a second adder. The carry leaving the group below then steers a two-way select between the two results.

The adder inside each upper group is chosen at build time. It can be a ripple chain or one of three logarithmic prefix networks: full-span doubling, sparse tree with a fan-back pass, or the odd-bit hybrid of the two. Every choice yields the same arithmetic result and differs only in logic depth and cell count.

The block has no clock, reset, handshake or state. Results follow the inputs combinationally, so a caller simply drives the operands and reads the sum.

Top module: `csa_sqrt_adder`

## Requirements
- R1: For every input combination and every adder selection, the concatenation {cout, sum} equals a + b + cin taken over WIDTH+1 bits.
- R2: Group boundaries follow a fixed rule. Nominal widths run 2, 2, 3, 4, 5, … from the LSB, and a group absorbs whatever remains when the bits left after it would be fewer than the next nominal width. This gives group start offsets 0, 2, 4, 7, 11 at 16 bits, 0, 2, 4, 7, 11, 16, 22 at 32 bits, and 0, 2, 4 at 8 bits.
- R3: The lowest group adds cin directly, so a = b = 0 with cin = 1 yields sum = 1 and cout = 0.
- R4: Each upper group's first-stage result equals the group's slice of a plus the slice of b with no carry-in, including its own carry-out bit.
- R5: When the carry entering an upper group is 1, that group's sum slice equals its first-stage slice plus one; when it is 0, the slice passes unchanged. This includes the case of an all-ones slice wrapping to zero.
- R6: The carry entering each upper group equals the carry out of adding all lower bits of a and b together with cin.
- R7: The KIND parameter selects the first-stage adder: 0 = ripple, 1 = full-span doubling prefix, 2 = sparse prefix with fan-back, 3 = odd-bit hybrid prefix. All four give identical results.
- R8: cout is the carry out of the most significant group; for example, 0x8000 + 0x8000 at 16 bits gives sum 0 and cout 1.
- R9: The 32-bit build meets R1 for arbitrary operands, including carries that run through every group.
- R10: At 8 bits, all 131072 combinations of a, b and cin meet R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top group |

## Verification
The hardest case to reach from the ports is an increment that overflows: an upper group whose zero-carry slice is all ones while a carry arrives from below. Here the incremented value must wrap to zero and hand a carry on to the next group. That carry must then pass through the next group's select as well. The stimulus reaches this in two ways. First, an all-ones operand is added to zero with cin set, which drives every group through its increment path at once. Second, for each group boundary, the value 2^k - 1 is added to 1 so that the carry stops exactly at that boundary. The same patterns run on all four adder selections at 8, 16 and 32 bits.

// File: rtl/csa_pkg.sv
package csa_pkg;

  typedef enum logic [1:0] {
    CSA_RIPPLE  = 2'd0,
    CSA_KOGGE   = 2'd1,
    CSA_BRENT   = 2'd2,
    CSA_HANCARL = 2'd3
  } csa_kind_e;

  // nominal width of group k before the remainder rule is applied
  function automatic int nom_width(int k);
    return (k == 0) ? 2 : k + 1;
  endfunction

  // first bit of group g; returns width once g reaches the group count
  function automatic int grp_lo(int width, int g);
    int pos;
    int k;
    int w;
    pos = 0;
    k   = 0;
    while (pos < width && k < g) begin
      w = nom_width(k);
      if (width - pos - w < nom_width(k + 1)) w = width - pos;
      pos = pos + w;
      k   = k + 1;
    end
    return pos;
  endfunction

  function automatic int grp_count(int width);
    int k;
    k = 0;
    while (grp_lo(width, k) < width) k = k + 1;
    return k;
  endfunction

  function automatic int clog2i(int n);
    int r;
    r = 0;
    while ((1 << r) < n) r = r + 1;
    return (r < 1) ? 1 : r;
  endfunction

  // partner node feeding bit i at prefix level lvl, or -1 for a pass-through
  function automatic int pf_partner(csa_kind_e kind, int n, int lvl, int i);
    int l2;
    int d;
    l2 = clog2i(n);
    if (i >= n) return -1;
    case (kind)
      CSA_KOGGE: begin
        if (lvl < l2) begin
          d = 1 << lvl;
          if (i >= d) return i - d;
        end
      end
      CSA_BRENT: begin
        if (lvl < l2) begin
          d = 1 << lvl;
          if ((i + 1) % (2 * d) == 0) return i - d;
        end else if (lvl < 2 * l2 - 1) begin
          d = 1 << (2 * l2 - 2 - lvl);
          if (((i + 1) % (2 * d) == d) && (i + 1 > 2 * d)) return i - d;
        end
      end
      CSA_HANCARL: begin
        if (lvl == 0) begin
          if (i % 2 == 1) return i - 1;
        end else if (lvl < l2) begin
          d = 1 << lvl;
          if ((i % 2 == 1) && (i > d)) return i - d;
        end else if (lvl == l2) begin
          if ((i % 2 == 0) && (i > 0)) return i - 1;
        end
      end
      default: ;
    endcase
    return -1;
  endfunction

endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  always_comb begin : ripple_chain
    logic c;
    c = ci;
    for (int i = 0; i < W; i++) begin
      s[i] = a[i] ^ b[i] ^ c;
      c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    co = c;
  end

endmodule

// File: rtl/csa_prefix.sv
module csa_prefix
  import csa_pkg::*;
#(
  parameter int unsigned W    = 4,
  parameter csa_kind_e   KIND = CSA_KOGGE
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s,
  output logic         co
);

  localparam int LG = clog2i(W);
  localparam int NL = 2 * LG;

  always_comb begin : prefix_net
    logic [W-1:0] g, p, gn, pn, h;
    int j;
    h = a ^ b;
    g = a & b;
    p = h;
    for (int lv = 0; lv < NL; lv++) begin
      gn = g;
      pn = p;
      for (int i = 0; i < W; i++) begin
        j = pf_partner(KIND, W, lv, i);
        if (j >= 0) begin
          gn[i] = g[i] | (p[i] & g[j]);
          pn[i] = p[i] & p[j];
        end
      end
      g = gn;
      p = pn;
    end
    // carry-in is zero, so the group term of [i:0] is the carry out of bit i
    s[0] = h[0];
    for (int i = 1; i < W; i++) s[i] = h[i] ^ g[i-1];
    co = g[W-1];
  end

endmodule

// File: rtl/csa_excess1.sv
module csa_excess1 #(
  parameter int unsigned W = 2
) (
  input  logic [W:0] x,
  output logic [W:0] y
);

  always_comb begin : inc_chain
    logic t;
    t = 1'b1;
    for (int i = 0; i <= W; i++) begin
      y[i] = x[i] ^ t;
      t    = t & x[i];
    end
  end

endmodule

// File: rtl/csa_zero_adder.sv
module csa_zero_adder
  import csa_pkg::*;
#(
  parameter int unsigned W    = 2,
  parameter csa_kind_e   KIND = CSA_RIPPLE
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s,
  output logic         co
);

  if (KIND == CSA_RIPPLE) begin : g_rca
    csa_ripple #(.W(W)) u_rca (
      .a(a), .b(b), .ci(1'b0), .s(s), .co(co)
    );
  end else begin : g_ppa
    csa_prefix #(.W(W), .KIND(KIND)) u_ppa (
      .a(a), .b(b), .s(s), .co(co)
    );
  end

endmodule

// File: rtl/csa_sqrt_adder.sv
module csa_sqrt_adder
  import csa_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter csa_kind_e   KIND  = CSA_RIPPLE
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NG = grp_count(WIDTH);

  logic [NG:0]      gc;   // carry entering each group, gc[NG] leaves the top
  logic [WIDTH-1:0] zs;   // first-stage sums of all groups
  logic [NG-1:0]    zc;   // first-stage carries of all groups

  assign gc[0] = cin;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int LO = grp_lo(WIDTH, g);
    localparam int HI = grp_lo(WIDTH, g + 1);
    localparam int GW = HI - LO;

    if (g == 0) begin : g_base
      csa_ripple #(.W(GW)) u_base (
        .a(a[HI-1:LO]), .b(b[HI-1:LO]), .ci(gc[0]),
        .s(zs[HI-1:LO]), .co(zc[0])
      );
      assign sum[HI-1:LO] = zs[HI-1:LO];
      assign gc[1]        = zc[0];
    end else begin : g_sel
      logic [GW-1:0] xs;
      logic          xc;

      csa_zero_adder #(.W(GW), .KIND(KIND)) u_add0 (
        .a(a[HI-1:LO]), .b(b[HI-1:LO]),
        .s(zs[HI-1:LO]), .co(zc[g])
      );

      csa_excess1 #(.W(GW)) u_inc (
        .x({zc[g], zs[HI-1:LO]}),
        .y({xc, xs})
      );

      assign sum[HI-1:LO] = gc[g] ? xs : zs[HI-1:LO];
      assign gc[g+1]      = gc[g] ? xc : zc[g];
    end
  end

  assign cout = gc[NG];

endmodule

// File: rtl/csa_sqrt_adder_chk.sv
module csa_sqrt_adder_chk
  import csa_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int          NG    = 5
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [NG:0]      gc,
  input logic [WIDTH-1:0] zs,
  input logic [NG-1:0]    zc
);

  logic [WIDTH:0] total;
  assign total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    assert_total_R1: assert ({cout, sum} == total)
      else $error("R1 total mismatch");
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int LO = grp_lo(WIDTH, g);
    localparam int HI = grp_lo(WIDTH, g + 1);
    localparam int GW = HI - LO;

    if (g == 0) begin : g_base
      logic [GW:0] zexp;
      assign zexp = {1'b0, a[HI-1:LO]} + {1'b0, b[HI-1:LO]} + {{GW{1'b0}}, cin};
      always_comb begin
        assert_base_cin_R3: assert ({zc[g], zs[HI-1:LO]} == zexp)
          else $error("R3 base group mismatch");
      end
    end else begin : g_up
      logic [GW:0]   zexp;
      logic [LO:0]   cref;
      logic [GW-1:0] sexp;
      assign zexp = {1'b0, a[HI-1:LO]} + {1'b0, b[HI-1:LO]};
      assign cref = {1'b0, a[LO-1:0]} + {1'b0, b[LO-1:0]} + {{LO{1'b0}}, cin};
      assign sexp = cref[LO] ? (zs[HI-1:LO] + {{(GW-1){1'b0}}, 1'b1}) : zs[HI-1:LO];
      always_comb begin
        assert_zero_stage_R4: assert ({zc[g], zs[HI-1:LO]} == zexp)
          else $error("R4 first stage mismatch in group %0d", g);
        assert_group_carry_R6: assert (gc[g] == cref[LO])
          else $error("R6 carry into group %0d wrong", g);
        assert_select_R5: assert (sum[HI-1:LO] == sexp)
          else $error("R5 selected slice wrong in group %0d", g);
      end
    end
  end

endmodule

bind csa_sqrt_adder csa_sqrt_adder_chk #(.WIDTH(WIDTH), .NG(NG)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
  .gc(gc), .zs(zs), .zc(zc)
);

// File: tb/csa_sqrt_adder_test.sv
module csa_sqrt_adder_test;
  import csa_pkg::*;

  logic        clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [31:0] a32 = '0;
  logic [31:0] b32 = '0;
  logic        cin = 1'b0;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [15:0] su;
  logic        cu;
  logic [7:0]  s8  [4];
  logic        c8  [4];
  logic [15:0] s16 [4];
  logic        c16 [4];
  logic [31:0] s32 [4];
  logic        c32 [4];

  csa_sqrt_adder #(.WIDTH(16), .KIND(CSA_RIPPLE)) uut (
    .a(a32[15:0]), .b(b32[15:0]), .cin(cin), .sum(su), .cout(cu)
  );

  for (genvar k = 0; k < 4; k++) begin : g_kind
    localparam csa_kind_e K = csa_kind_e'(k);
    csa_sqrt_adder #(.WIDTH(8), .KIND(K)) u8 (
      .a(a32[7:0]), .b(b32[7:0]), .cin(cin), .sum(s8[k]), .cout(c8[k]));
    csa_sqrt_adder #(.WIDTH(16), .KIND(K)) u16 (
      .a(a32[15:0]), .b(b32[15:0]), .cin(cin), .sum(s16[k]), .cout(c16[k]));
    csa_sqrt_adder #(.WIDTH(32), .KIND(K)) u32 (
      .a(a32), .b(b32), .cin(cin), .sum(s32[k]), .cout(c32[k]));
  end

  task automatic chk(string req, string what, logic [32:0] got, logic [32:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s %s got %h exp %h", req, what, got, exp);
    end
  endtask

  task automatic apply(logic [31:0] x, logic [31:0] y, logic c);
    a32 = x;
    b32 = y;
    cin = c;
    #2;
  endtask

  // compares every instance with the reference sum of the current inputs
  task automatic verify(string req, bit w8, bit w16, bit w32);
    logic [32:0] e8, e16, e32;
    e8  = 33'({1'b0, a32[7:0]} + {1'b0, b32[7:0]} + {8'd0, cin});
    e16 = 33'({1'b0, a32[15:0]} + {1'b0, b32[15:0]} + {16'd0, cin});
    e32 = {1'b0, a32} + {1'b0, b32} + {32'd0, cin};
    if (w16) chk(req, "uut", 33'({cu, su}), e16);
    for (int k = 0; k < 4; k++) begin
      if (w8)  chk(req, $sformatf("w8 kind%0d", k),  33'({c8[k], s8[k]}), e8);
      if (w16) chk(req, $sformatf("w16 kind%0d", k), 33'({c16[k], s16[k]}), e16);
      if (w32) chk(req, $sformatf("w32 kind%0d", k), {c32[k], s32[k]}, e32);
    end
  endtask

  task automatic t_idle;
    apply(32'd0, 32'd0, 1'b0);
    chk("R1", "zero inputs", 33'({cu, su}), 33'd0);
    verify("R1", 1, 1, 1);
  endtask

  task automatic t_layout;
    int e16 [6] = '{0, 2, 4, 7, 11, 16};
    int e32 [8] = '{0, 2, 4, 7, 11, 16, 22, 32};
    int e8  [4] = '{0, 2, 4, 8};
    for (int g = 0; g < 6; g++) chk("R2", "lo16", 33'(grp_lo(16, g)), 33'(e16[g]));
    for (int g = 0; g < 8; g++) chk("R2", "lo32", 33'(grp_lo(32, g)), 33'(e32[g]));
    for (int g = 0; g < 4; g++) chk("R2", "lo8",  33'(grp_lo(8, g)),  33'(e8[g]));
    chk("R2", "count16", 33'(grp_count(16)), 33'd5);
    chk("R2", "count32", 33'(grp_count(32)), 33'd7);
  endtask

  task automatic t_cin_base;
    apply(32'd0, 32'd0, 1'b1);
    chk("R3", "cin only", 33'({cu, su}), 33'd1);
    verify("R3", 1, 1, 1);
  endtask

  task automatic t_full_chain;
    // all-ones plus cin: every upper group takes its overflowing increment path
    apply(32'hFFFF_FFFF, 32'd0, 1'b1);
    chk("R5", "ones+cin", 33'({cu, su}), 33'h1_0000);
    verify("R5", 1, 1, 1);
    apply(32'd0, 32'hFFFF_FFFF, 1'b1);
    verify("R5", 1, 1, 1);
    apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    verify("R5", 1, 1, 1);
    apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
    verify("R4", 1, 1, 1);
  endtask

  task automatic t_boundaries;
    int b32l [8] = '{0, 2, 4, 7, 11, 16, 22, 32};
    for (int g = 1; g < 8; g++) begin
      // carry dies exactly at the start of group g
      apply(32'((64'd1 << b32l[g]) - 1), 32'd1, 1'b0);
      verify("R6", 1, 1, 1);
      apply(32'((64'd1 << b32l[g]) - 1), 32'd0, 1'b1);
      verify("R6", 1, 1, 1);
      apply(32'((64'd1 << b32l[g]) - 2), 32'd1, 1'b0);
      verify("R4", 1, 1, 1);
    end
  endtask

  task automatic t_msb;
    apply(32'h0000_8000, 32'h0000_8000, 1'b0);
    chk("R8", "msb16", 33'({cu, su}), 33'h1_0000);
    verify("R8", 0, 1, 0);
    apply(32'h8000_0000, 32'h8000_0000, 1'b0);
    verify("R8", 0, 0, 1);
    apply(32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
    verify("R8", 1, 1, 1);
  endtask

  task automatic t_exhaust8;
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        for (int c = 0; c < 2; c++) begin
          apply(32'(x), 32'(y), c[0]);
          verify("R10", 1, 0, 0);
        end
  endtask

  task automatic t_random;
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      apply($urandom, $urandom, n[0]);
      verify("R7", 0, 1, 0);
      verify("R9", 0, 0, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_idle();
    t_layout();
    t_cin_base();
    t_full_chain();
    t_boundaries();
    t_msb();
    t_exhaust8();
    t_random();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule